// File: doc/BRIEF.md
# Bus Turnaround Scheduler

This block decides when a serial display link transmitter hands the bus back to the peripheral after packets on one virtual channel. It watches packet starts (short or long, with the header word count) and payload writes of 32-bit words. From these it finds the moment each packet has fully left. At that moment it raises a turnaround request when the automatic enable for that packet type is set.

Software may also ask for a turnaround at any time through a manual request bit. Hardware clears that bit once the turnaround has gone out. Automatic and manual requests that are pending together merge into a single turnaround. In video mode a turnaround is held back until the link is in a blanking phase that carries no high-speed blanking packets. Packets that arrive through the video port also raise a one-cycle packet-sent interrupt when they finish.

Top module: `bta_scheduler`

## Requirements
- R1: With `auto_short_en`=1, exactly one `bta_issue` pulse follows each short packet (a `pkt_start` with `pkt_long`=0). With `auto_short_en`=0 and no manual request, no pulse follows.
- R2: With `auto_long_en`=1, exactly one `bta_issue` pulse follows each long packet. With `auto_long_en`=0 and no manual request, no pulse follows.
- R3: A long packet ends on the `pay_wr` that brings the transferred byte total to `pkt_wc`. Each write carries up to 4 bytes, so ceil(`pkt_wc`/4) writes end it. A long packet with `pkt_wc`=0, and any short packet, ends with no writes at all.
- R4: When a manual request and an automatic condition are pending together, exactly one `bta_issue` pulse is produced. After the pulse, `sw_bta_q` reads 0.
- R5: A manual request (`sw_bta_set` pulse, visible on `sw_bta_q`=1) with no packet in progress produces one `bta_issue` pulse and then clears `sw_bta_q`. While a long packet's payload is still outstanding, no pulse is produced.
- R6: While `vid_mode`=1, no `bta_issue` pulse occurs unless `vid_blank`=1 and all four of `hsblk_all`, `hsblk_hfp`, `hsblk_hbp` and `hsblk_hsa` are 0. The request stays pending until that holds.
- R7: A packet started with `pkt_from_vport`=1 produces exactly one `pkt_sent_irq` pulse, one cycle after it ends. A packet with `pkt_from_vport`=0 produces none.
- R8: Synchronous reset (`rst`=1) clears any pending request, `sw_bta_q`, both output pulses and the byte counter.
- R9: `pkt_start` is ignored while a long packet's payload is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Packet header accepted strobe |
| pkt_long | input | 1 | 1 = long packet, 0 = short packet |
| pkt_wc | input | 16 | Long packet payload byte count |
| pkt_from_vport | input | 1 | Packet supplied through the video port |
| pay_wr | input | 1 | One 32-bit payload word written |
| auto_short_en | input | 1 | Automatic turnaround after short packets |
| auto_long_en | input | 1 | Automatic turnaround after long packets |
| sw_bta_set | input | 1 | Software sets the manual request bit |
| hsblk_all | input | 1 | General HS blanking mode |
| hsblk_hfp | input | 1 | HS blanking in horizontal front porch |
| hsblk_hbp | input | 1 | HS blanking in horizontal back porch |
| hsblk_hsa | input | 1 | HS blanking in horizontal sync active |
| vid_mode | input | 1 | Channel is running video mode |
| vid_blank | input | 1 | Video timing is in a blanking phase |
| sw_bta_q | output | 1 | Manual request bit readback |
| bta_issue | output | 1 | One-cycle turnaround issue pulse |
| pkt_sent_irq | output | 1 | One-cycle video-port packet-sent pulse |

## Verification
On every cycle the assertions check four things. A turnaround never issues while payload is outstanding. In video mode it issues only in a blanking phase free of HS blanking. The manual bit drops after the pulse it caused. The interrupt only follows a packet end.

The directed scenarios are needed for the counting behaviour. They show that auto and manual requests merge into exactly one pulse, that the packet end falls on ceil(wc/4) writes, and that a disabled auto mode gives no pulse. They also show that a request blocked by blanking is released later rather than lost.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef struct packed {
    logic all;
    logic hfp;
    logic hbp;
    logic hsa;
  } hsblk_t;

  function automatic logic hsblk_any(input hsblk_t b);
    return b.all | b.hfp | b.hbp | b.hsa;
  endfunction
endpackage

// File: rtl/bta_pkt_tracker.sv
module bta_pkt_tracker #(
  parameter int WC_W         = 16,
  parameter int BYTES_PER_WR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pkt_start,
  input  logic            pkt_long,
  input  logic [WC_W-1:0] pkt_wc,
  input  logic            pkt_from_vport,
  input  logic            pay_wr,
  output logic            in_pkt,
  output logic            end_q,
  output logic            end_long_q,
  output logic            end_vport_q
);
  localparam logic [WC_W-1:0] BPW = WC_W'(BYTES_PER_WR);

  logic [WC_W-1:0] rem_q;
  logic            long_q;
  logic            vport_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q       <= '0;
      in_pkt      <= 1'b0;
      end_q       <= 1'b0;
      end_long_q  <= 1'b0;
      end_vport_q <= 1'b0;
      long_q      <= 1'b0;
      vport_q     <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (!in_pkt && pkt_start) begin
        if (!pkt_long || pkt_wc == '0) begin
          end_q       <= 1'b1;
          end_long_q  <= pkt_long;
          end_vport_q <= pkt_from_vport;
        end else begin
          rem_q   <= pkt_wc;
          in_pkt  <= 1'b1;
          long_q  <= 1'b1;
          vport_q <= pkt_from_vport;
        end
      end else if (in_pkt && pay_wr) begin
        if (rem_q <= BPW) begin
          rem_q       <= '0;
          in_pkt      <= 1'b0;
          end_q       <= 1'b1;
          end_long_q  <= long_q;
          end_vport_q <= vport_q;
        end else begin
          rem_q <= rem_q - BPW;
        end
      end
    end
  end

  AST_REM_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(in_pkt) |-> rem_q == '0); // R3
endmodule

// File: rtl/bta_gate.sv
module bta_gate
  import bta_pkg::*;
(
  input  logic   vid_mode,
  input  logic   vid_blank,
  input  hsblk_t hsblk,
  output logic   gate_ok
);
  always_comb begin
    gate_ok = !vid_mode || (vid_blank && !hsblk_any(hsblk));
  end
endmodule

// File: rtl/bta_req_merge.sv
module bta_req_merge (
  input  logic clk,
  input  logic rst,
  input  logic pkt_end,
  input  logic pkt_end_long,
  input  logic in_pkt,
  input  logic auto_short_en,
  input  logic auto_long_en,
  input  logic sw_bta_set,
  input  logic gate_ok,
  output logic issue_now,
  output logic sw_bta_q,
  output logic bta_issue
);
  logic auto_pend_q;
  logic auto_hit;

  always_comb begin
    auto_hit  = pkt_end && (pkt_end_long ? auto_long_en : auto_short_en);
    issue_now = (auto_pend_q || sw_bta_q) && !in_pkt && gate_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_pend_q <= 1'b0;
      sw_bta_q    <= 1'b0;
      bta_issue   <= 1'b0;
    end else begin
      bta_issue   <= issue_now;
      auto_pend_q <= issue_now ? 1'b0 : (auto_pend_q || auto_hit);
      sw_bta_q    <= sw_bta_set || (sw_bta_q && !issue_now);
    end
  end

  AST_MAN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(issue_now) && !$past(sw_bta_set) |-> !sw_bta_q); // R4
endmodule

// File: rtl/bta_scheduler.sv
module bta_scheduler
  import bta_pkg::*;
#(
  parameter int WC_W         = 16,
  parameter int BYTES_PER_WR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pkt_start,
  input  logic            pkt_long,
  input  logic [WC_W-1:0] pkt_wc,
  input  logic            pkt_from_vport,
  input  logic            pay_wr,
  input  logic            auto_short_en,
  input  logic            auto_long_en,
  input  logic            sw_bta_set,
  input  logic            hsblk_all,
  input  logic            hsblk_hfp,
  input  logic            hsblk_hbp,
  input  logic            hsblk_hsa,
  input  logic            vid_mode,
  input  logic            vid_blank,
  output logic            sw_bta_q,
  output logic            bta_issue,
  output logic            pkt_sent_irq
);
  logic   in_pkt, end_q, end_long_q, end_vport_q;
  logic   gate_ok, issue_now;
  hsblk_t hsblk;

  assign hsblk = '{all: hsblk_all, hfp: hsblk_hfp, hbp: hsblk_hbp, hsa: hsblk_hsa};

  bta_pkt_tracker #(.WC_W(WC_W), .BYTES_PER_WR(BYTES_PER_WR)) u_trk (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_long(pkt_long),
    .pkt_wc(pkt_wc), .pkt_from_vport(pkt_from_vport), .pay_wr(pay_wr),
    .in_pkt(in_pkt), .end_q(end_q), .end_long_q(end_long_q),
    .end_vport_q(end_vport_q)
  );

  bta_gate u_gate (
    .vid_mode(vid_mode), .vid_blank(vid_blank), .hsblk(hsblk), .gate_ok(gate_ok)
  );

  bta_req_merge u_merge (
    .clk(clk), .rst(rst), .pkt_end(end_q), .pkt_end_long(end_long_q),
    .in_pkt(in_pkt), .auto_short_en(auto_short_en), .auto_long_en(auto_long_en),
    .sw_bta_set(sw_bta_set), .gate_ok(gate_ok), .issue_now(issue_now),
    .sw_bta_q(sw_bta_q), .bta_issue(bta_issue)
  );

  always_ff @(posedge clk) begin
    if (rst) pkt_sent_irq <= 1'b0;
    else     pkt_sent_irq <= end_q && end_vport_q;
  end

  AST_NO_MID_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    in_pkt |-> !issue_now); // R5
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    bta_issue && $past(vid_mode) |->
      $past(vid_blank) && !$past(hsblk_all | hsblk_hfp | hsblk_hbp | hsblk_hsa)); // R6
  AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    pkt_sent_irq |-> $past(end_q)); // R7
endmodule

// File: tb/sim_bta_scheduler.sv
`timescale 1ns/1ps
module sim_bta_scheduler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_start = 0, pkt_long = 0, pkt_from_vport = 0, pay_wr = 0;
  logic [15:0] pkt_wc = '0;
  logic auto_short_en = 0, auto_long_en = 0, sw_bta_set = 0;
  logic hsblk_all = 0, hsblk_hfp = 0, hsblk_hbp = 0, hsblk_hsa = 0;
  logic vid_mode = 0, vid_blank = 0;
  logic sw_bta_q, bta_issue, pkt_sent_irq;

  int n_run = 0, n_fail = 0;
  int bta_cnt, irq_cnt;
  logic done = 0;

  always #2 clk = ~clk;

  bta_scheduler u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bta_issue) bta_cnt++;
      if (pkt_sent_irq) irq_cnt++;
    end
  endtask

  task automatic clr();
    bta_cnt = 0;
    irq_cnt = 0;
  endtask

  task automatic send(input logic lng, input int wc, input logic vp);
    @(negedge clk);
    pkt_start = 1; pkt_long = lng; pkt_wc = 16'(wc); pkt_from_vport = vp;
    @(negedge clk);
    if (bta_issue) bta_cnt++;
    if (pkt_sent_irq) irq_cnt++;
    pkt_start = 0;
  endtask

  task automatic write1();
    pay_wr = 1;
    @(negedge clk);
    if (bta_issue) bta_cnt++;
    if (pkt_sent_irq) irq_cnt++;
    pay_wr = 0;
  endtask

  task automatic t_reset();
    chk("R8 bta after reset", int'(bta_issue), 0);
    chk("R8 irq after reset", int'(pkt_sent_irq), 0);
    chk("R8 man bit after reset", int'(sw_bta_q), 0);
    vid_mode = 1;
    @(negedge clk); sw_bta_set = 1; @(negedge clk); sw_bta_set = 0;
    chk("R8 man bit set", int'(sw_bta_q), 1);
    rst = 1; @(negedge clk); rst = 0; vid_mode = 0;
    clr(); idle(6);
    chk("R8 man bit cleared by reset", int'(sw_bta_q), 0);
    chk("R8 no pulse after reset", bta_cnt, 0);
  endtask

  task automatic t_short();
    auto_short_en = 1; clr(); send(0, 0, 0); idle(6);
    chk("R1 short auto pulse", bta_cnt, 1);
    auto_short_en = 0; clr(); send(0, 0, 0); idle(6);
    chk("R1 short auto off", bta_cnt, 0);
  endtask

  task automatic t_long();
    auto_long_en = 1; clr();
    send(1, 10, 0); write1(); write1(); idle(4);
    chk("R3 no end after 8 of 10 bytes", bta_cnt, 0);
    write1(); idle(6);
    chk("R2 R3 long auto pulse after 3 writes", bta_cnt, 1);
    clr(); send(1, 8, 0); write1(); idle(3);
    chk("R3 no end after 4 of 8 bytes", bta_cnt, 0);
    write1(); idle(6);
    chk("R3 end after 2 writes of wc=8", bta_cnt, 1);
    clr(); send(1, 0, 0); idle(6);
    chk("R3 wc=0 ends at start", bta_cnt, 1);
    auto_long_en = 0; clr(); send(1, 4, 0); write1(); idle(6);
    chk("R2 long auto off", bta_cnt, 0);
  endtask

  task automatic t_ignore_start();
    auto_short_en = 1; auto_long_en = 1; clr();
    send(1, 12, 0); write1();
    send(0, 0, 0); idle(4);
    chk("R9 start ignored mid payload", bta_cnt, 0);
    write1(); write1(); idle(6);
    chk("R9 original packet still ends on its count", bta_cnt, 1);
    auto_short_en = 0; auto_long_en = 0;
  endtask

  task automatic t_merge();
    auto_long_en = 1; clr();
    send(1, 8, 0); write1();
    @(negedge clk); sw_bta_set = 1; @(negedge clk); sw_bta_set = 0;
    idle(3);
    chk("R5 held during payload", bta_cnt, 0);
    chk("R5 man bit pending", int'(sw_bta_q), 1);
    write1(); idle(8);
    chk("R4 merged single pulse", bta_cnt, 1);
    chk("R4 man bit cleared", int'(sw_bta_q), 0);
    auto_long_en = 0;
  endtask

  task automatic t_manual();
    clr();
    @(negedge clk); sw_bta_set = 1; @(negedge clk); sw_bta_set = 0;
    idle(6);
    chk("R5 manual without packet", bta_cnt, 1);
    chk("R5 man bit self clear", int'(sw_bta_q), 0);
  endtask

  task automatic t_video();
    vid_mode = 1; vid_blank = 0; clr();
    @(negedge clk); sw_bta_set = 1; @(negedge clk); sw_bta_set = 0;
    idle(6);
    chk("R6 held outside blanking", bta_cnt, 0);
    vid_blank = 1; hsblk_hfp = 1; idle(6);
    chk("R6 held with HFP blanking", bta_cnt, 0);
    hsblk_hfp = 0; hsblk_all = 1; idle(6);
    chk("R6 held with general blanking", bta_cnt, 0);
    chk("R6 request still pending", int'(sw_bta_q), 1);
    hsblk_all = 0; idle(6);
    chk("R6 released in clean blanking", bta_cnt, 1);
    vid_mode = 0; vid_blank = 0;
  endtask

  task automatic t_irq();
    clr(); send(1, 6, 1); write1(); write1(); idle(5);
    chk("R7 irq for video port packet", irq_cnt, 1);
    clr(); send(0, 0, 1); idle(5);
    chk("R7 irq for video short packet", irq_cnt, 1);
    clr(); send(1, 4, 0); write1(); idle(5);
    chk("R7 no irq for command port", irq_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_ignore_start();
    t_merge();
    t_manual();
    t_video();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule